// File: doc/BRIEF.md
# Nested Prioritized Event Controller

This block picks the next event a processor core should service. It has two stages. Peripheral interrupt lines enter a system stage first. There, each line has its own enable and a programmable target field that steers it onto one of the peripheral core levels, 7 to 13. The core stage also takes the dedicated events (emulation, reset request, non-maskable interrupt and exception) and two software interrupt requests. Every request is latched as pending. The highest-priority eligible pending level is offered on `evt_valid` and `evt_level`.

The core takes an offered event by pulsing `evt_ack`. In that cycle the level becomes active, its pending bit clears and its return address register stores `cur_pc`. Nesting works as follows. A pending level is offered only while its number is strictly lower than that of every active level, so a more urgent event can preempt the handler that is running. A pulse on `evt_rti` ends the most urgent active level. `ret_addr` always shows the return address of the most urgent active level, so the core can read where to resume.

Top module: `evt_ctrl_top`

## Requirements
- R1: After reset, no level is pending or active, `evt_valid` is 0, `active_lvls` is 0 and `ret_addr` is 0.
- R2: Peripheral i is routed to the level held in `periph_route[4i+3:4i]` when that value is between 7 and 13. A value outside 7..13, or `periph_en[i]`=0, makes the request have no effect.
- R3: A lower level number has higher priority. The dedicated levels are emulation=0, reset request=1, non-maskable=2 and exception=3, and all of them win over levels 7..15. Levels 4..6 are never offered.
- R4: `lvl_en[k]` enables level 7+k. A disabled level is not offered, but it keeps its pending request and is offered again once it is enabled. Levels 0..3 cannot be disabled.
- R5: A request pulse of one cycle stays pending until that level is acknowledged.
- R6: `evt_ack` while `evt_valid`=1 sets the offered level's bit in `active_lvls` and clears its pending bit. After that edge `ret_addr` equals the `cur_pc` value sampled at the acknowledge.
- R7: A pending level is offered only if its number is lower than that of every active level. A request at the same level or at a less urgent level waits.
- R8: `evt_rti` clears the lowest-numbered set bit of `active_lvls`. `ret_addr` then shows the return address of the next active level, or 0 if no level is active.
- R9: `evt_ack` while `evt_valid`=0 has no effect. `evt_rti` while no level is active has no effect.
- R10: `swi_req[0]` requests level 14 and `swi_req[1]` requests level 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| periph_req | input | N_PERIPH | Peripheral request lines |
| periph_en | input | N_PERIPH | Per-peripheral enable |
| periph_route | input | 4*N_PERIPH | Target core level per peripheral, 4 bits each |
| emu_req | input | 1 | Emulation event request (level 0) |
| rst_req | input | 1 | Reset event request (level 1) |
| nmi_req | input | 1 | Non-maskable interrupt request (level 2) |
| exc_req | input | 1 | Synchronous exception request (level 3) |
| swi_req | input | 2 | Software interrupt requests (levels 14, 15) |
| lvl_en | input | 9 | Enable for levels 7..15 (bit k = level 7+k) |
| evt_ack | input | 1 | Core takes the offered event |
| cur_pc | input | ADDR_W | Address to save on acknowledge |
| evt_rti | input | 1 | Return from the current event |
| evt_valid | output | 1 | An event is offered |
| evt_level | output | 4 | Offered level number |
| active_lvls | output | 16 | Active level bitmap |
| ret_addr | output | ADDR_W | Return address of the most urgent active level |

## Verification
The bench targets the nesting boundary. A request at the same level as the running handler must wait, and a design that compares with "less or equal" would grant it again on top of itself. It also checks that a request held under a level disable survives and comes back when the level is enabled. A design that dropped the request would lose the interrupt silently. Further checks cover an out-of-range route value, an acknowledge with nothing offered and a return with nothing active. A loose decode there would create active levels that no one asked for or would store a bogus return address. Finally, two returns in a row must reveal the outer handler's saved address and then release the pending requests that waited behind the nest.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int NUM_LVL  = 16;
  localparam int LVL_W    = 4;
  localparam int IDX_W    = 5;
  localparam int GP_FIRST = 7;
  localparam int PER_LAST = 13;
  localparam int NUM_GP   = NUM_LVL - GP_FIRST;
  localparam int NUM_DED  = 4;

  // Index of the lowest set bit, NUM_LVL when none is set.
  function automatic logic [IDX_W-1:0] first_set(input logic [NUM_LVL-1:0] v);
    logic [IDX_W-1:0] r;
    r = IDX_W'(NUM_LVL);
    for (int i = NUM_LVL - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/evt_sys_map.sv
module evt_sys_map
  import evt_pkg::*;
#(
  parameter int N_PERIPH = 8
) (
  input  logic [N_PERIPH-1:0]       req,
  input  logic [N_PERIPH-1:0]       en,
  input  logic [N_PERIPH*LVL_W-1:0] route,
  output logic [NUM_LVL-1:0]        lvl_set
);
  logic [NUM_LVL-1:0] hit [N_PERIPH];

  for (genvar i = 0; i < N_PERIPH; i++) begin : g_line
    logic [LVL_W-1:0] tgt;
    logic             in_range;
    assign tgt      = route[i*LVL_W +: LVL_W];
    assign in_range = (tgt >= LVL_W'(GP_FIRST)) && (tgt <= LVL_W'(PER_LAST));
    always_comb begin
      hit[i] = '0;
      if (req[i] && en[i] && in_range) hit[i][tgt] = 1'b1;
    end
  end

  always_comb begin
    lvl_set = '0;
    for (int i = 0; i < N_PERIPH; i++) lvl_set = lvl_set | hit[i];
  end
endmodule

// File: rtl/evt_core_arb.sv
module evt_core_arb
  import evt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LVL-1:0] set_vec,
  input  logic [NUM_LVL-1:0] en_vec,
  input  logic               ack,
  input  logic               rti,
  output logic               valid,
  output logic [LVL_W-1:0]   grant,
  output logic               take,
  output logic [NUM_LVL-1:0] act,
  output logic [IDX_W-1:0]   top_act
);
  logic [NUM_LVL-1:0] pend_q, pend_d, act_q, act_d;
  logic [IDX_W-1:0]   best;
  logic               upd_en;

  assign best    = first_set(pend_q & en_vec);
  assign top_act = first_set(act_q);
  assign valid   = best < top_act;
  assign grant   = best[LVL_W-1:0];
  assign take    = ack && valid;
  assign act     = act_q;

  always_comb begin
    pend_d = pend_q;
    act_d  = act_q;
    if (take) pend_d[grant] = 1'b0;
    pend_d = pend_d | set_vec;
    if (rti && (act_q != '0)) act_d[top_act[LVL_W-1:0]] = 1'b0;
    if (take) act_d[grant] = 1'b1;
  end

  assign upd_en = take || rti || (set_vec != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else if (upd_en) begin
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end
endmodule

// File: rtl/evt_ret_store.sv
module evt_ret_store
  import evt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [LVL_W-1:0]  grant,
  input  logic [ADDR_W-1:0] pc,
  input  logic [IDX_W-1:0]  top_act,
  output logic [ADDR_W-1:0] ret_out
);
  logic [ADDR_W-1:0] ret_q [NUM_LVL];

  for (genvar k = 0; k < NUM_LVL; k++) begin : g_lvl
    if (k < NUM_DED || k >= GP_FIRST) begin : g_reg
      logic wr_en;
      assign wr_en = take && (grant == LVL_W'(k));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ret_q[k] <= '0;
        else if (wr_en) ret_q[k] <= pc;
      end
    end else begin : g_none
      assign ret_q[k] = '0;
    end
  end

  always_comb begin
    ret_out = '0;
    if (top_act < IDX_W'(NUM_LVL)) ret_out = ret_q[top_act[LVL_W-1:0]];
  end
endmodule

// File: rtl/evt_ctrl_top.sv
module evt_ctrl_top
  import evt_pkg::*;
#(
  parameter int N_PERIPH = 8,
  parameter int ADDR_W   = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_PERIPH-1:0]       periph_req,
  input  logic [N_PERIPH-1:0]       periph_en,
  input  logic [N_PERIPH*LVL_W-1:0] periph_route,
  input  logic                      emu_req,
  input  logic                      rst_req,
  input  logic                      nmi_req,
  input  logic                      exc_req,
  input  logic [1:0]                swi_req,
  input  logic [NUM_GP-1:0]         lvl_en,
  input  logic                      evt_ack,
  input  logic [ADDR_W-1:0]         cur_pc,
  input  logic                      evt_rti,
  output logic                      evt_valid,
  output logic [LVL_W-1:0]          evt_level,
  output logic [NUM_LVL-1:0]        active_lvls,
  output logic [ADDR_W-1:0]         ret_addr
);
  logic               rst_meta, rst_sync;
  logic [NUM_LVL-1:0] per_set, set_vec, en_vec;
  logic               take;
  logic [IDX_W-1:0]   top_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  evt_sys_map #(.N_PERIPH(N_PERIPH)) i_map (
    .req(periph_req), .en(periph_en), .route(periph_route), .lvl_set(per_set)
  );

  always_comb begin
    set_vec = per_set;
    set_vec[0]           = emu_req;
    set_vec[1]           = rst_req;
    set_vec[2]           = nmi_req;
    set_vec[3]           = exc_req;
    set_vec[NUM_LVL-2]   = swi_req[0];
    set_vec[NUM_LVL-1]   = swi_req[1];
    en_vec = {lvl_en, {(GP_FIRST-NUM_DED){1'b0}}, {NUM_DED{1'b1}}};
  end

  evt_core_arb i_arb (
    .clk(clk), .rst_n(rst_sync), .set_vec(set_vec), .en_vec(en_vec),
    .ack(evt_ack), .rti(evt_rti), .valid(evt_valid), .grant(evt_level),
    .take(take), .act(active_lvls), .top_act(top_act)
  );

  evt_ret_store #(.ADDR_W(ADDR_W)) i_ret (
    .clk(clk), .rst_n(rst_sync), .take(take), .grant(evt_level),
    .pc(cur_pc), .top_act(top_act), .ret_out(ret_addr)
  );
endmodule

// File: rtl/evt_ctrl_chk.sv
module evt_ctrl_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_ack,
  input logic              evt_rti,
  input logic [ADDR_W-1:0] cur_pc,
  input logic              evt_valid,
  input logic [3:0]        evt_level,
  input logic [15:0]       active_lvls,
  input logic [ADDR_W-1:0] ret_addr
);
  logic [31:0] upto;
  logic        took;
  assign upto = (32'h2 << evt_level) - 32'h1;
  assign took = evt_ack && evt_valid;

  // R6
  ack_sets_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> active_lvls[$past(evt_level)]);
  // R6
  ret_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> ret_addr == $past(cur_pc));
  // R7
  nest_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> ((32'(active_lvls) & upto) == 32'h0));
  // R3
  level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (evt_level <= 4'd3 || evt_level >= 4'd7));
  // R8
  rti_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rti && !took && active_lvls != 16'h0) |=>
      $countones(active_lvls) == $countones($past(active_lvls)) - 1);
  // R9
  rti_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rti && !took && active_lvls == 16'h0) |=> active_lvls == 16'h0);
endmodule

bind evt_ctrl_top evt_ctrl_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .evt_ack(evt_ack), .evt_rti(evt_rti),
  .cur_pc(cur_pc), .evt_valid(evt_valid), .evt_level(evt_level),
  .active_lvls(active_lvls), .ret_addr(ret_addr)
);

// File: tb/test_evt_ctrl_top.sv
module test_evt_ctrl_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  periph_req, periph_en;
  logic [31:0] periph_route;
  logic        emu_req, rst_req, nmi_req, exc_req;
  logic [1:0]  swi_req;
  logic [8:0]  lvl_en;
  logic        evt_ack, evt_rti;
  logic [31:0] cur_pc;
  logic        evt_valid;
  logic [3:0]  evt_level;
  logic [15:0] active_lvls;
  logic [31:0] ret_addr;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  evt_ctrl_top i_evt_ctrl_top (
    .clk(clk), .rst_n(rst_n), .periph_req(periph_req), .periph_en(periph_en),
    .periph_route(periph_route), .emu_req(emu_req), .rst_req(rst_req),
    .nmi_req(nmi_req), .exc_req(exc_req), .swi_req(swi_req), .lvl_en(lvl_en),
    .evt_ack(evt_ack), .cur_pc(cur_pc), .evt_rti(evt_rti),
    .evt_valid(evt_valid), .evt_level(evt_level),
    .active_lvls(active_lvls), .ret_addr(ret_addr)
  );

  typedef struct packed {
    logic [3:0] ded;   // emu, rst, nmi, exc
    logic [1:0] swi;
    logic [7:0] preq;
    logic [7:0] pen;
    logic [8:0] len;
    logic       ev;
    logic [3:0] lv;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{4'b0000, 2'b00, 8'h01, 8'hFF, 9'h1FF, 1'b1, 4'd7 },  // R2
    '{4'b0000, 2'b00, 8'h40, 8'hFF, 9'h1FF, 1'b1, 4'd13},  // R2
    '{4'b0000, 2'b00, 8'h80, 8'hFF, 9'h1FF, 1'b0, 4'd0 },  // R2 route 4
    '{4'b0000, 2'b00, 8'h04, 8'hFB, 9'h1FF, 1'b0, 4'd0 },  // R2 disabled line
    '{4'b0000, 2'b00, 8'h0C, 8'hFF, 9'h1FF, 1'b1, 4'd9 },  // R3
    '{4'b0000, 2'b01, 8'h00, 8'hFF, 9'h1FF, 1'b1, 4'd14},  // R10
    '{4'b0000, 2'b10, 8'h00, 8'hFF, 9'h1FF, 1'b1, 4'd15},  // R10
    '{4'b0001, 2'b00, 8'h01, 8'hFF, 9'h1FF, 1'b1, 4'd3 },  // R3
    '{4'b0011, 2'b00, 8'h00, 8'hFF, 9'h1FF, 1'b1, 4'd2 },  // R3
    '{4'b0110, 2'b00, 8'h00, 8'hFF, 9'h1FF, 1'b1, 4'd1 },  // R3
    '{4'b1111, 2'b11, 8'hFF, 8'hFF, 9'h1FF, 1'b1, 4'd0 },  // R3
    '{4'b0000, 2'b00, 8'h03, 8'hFF, 9'h1FE, 1'b1, 4'd8 },  // R4
    '{4'b0010, 2'b00, 8'h00, 8'hFF, 9'h000, 1'b1, 4'd2 }   // R4
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_in();
    periph_req = '0; emu_req = 0; rst_req = 0; nmi_req = 0; exc_req = 0;
    swi_req = '0; evt_ack = 0; evt_rti = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_in();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_req(input logic [7:0] p);
    periph_req = p;
    @(negedge clk);
    periph_req = '0;
  endtask

  task automatic ack_at(input logic [31:0] pc);
    evt_ack = 1; cur_pc = pc;
    @(negedge clk);
    evt_ack = 0;
  endtask

  task automatic rti_once();
    evt_rti = 1;
    @(negedge clk);
    evt_rti = 0;
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; idle_in(); cur_pc = '0;
    periph_en = 8'hFF; lvl_en = 9'h1FF;
    periph_route = {4'd4, 4'd13, 4'd12, 4'd11, 4'd10, 4'd9, 4'd8, 4'd7};

    for (int i = 0; i < NV; i++) begin
      do_reset();
      periph_en = VEC[i].pen; lvl_en = VEC[i].len;
      {emu_req, rst_req, nmi_req, exc_req} = VEC[i].ded;
      swi_req = VEC[i].swi; periph_req = VEC[i].preq;
      @(negedge clk);
      idle_in();
      chk("R2/R3/R4/R10 valid", 32'(evt_valid), 32'(VEC[i].ev));
      if (VEC[i].ev) chk("R3 level", 32'(evt_level), 32'(VEC[i].lv));
    end

    periph_en = 8'hFF; lvl_en = 9'h1FF;
    do_reset();
    chk("R1 valid", 32'(evt_valid), 0);
    chk("R1 active", 32'(active_lvls), 0);
    chk("R1 ret", ret_addr, 0);

    pulse_req(8'h04);                 // level 9
    repeat (3) @(negedge clk);
    chk("R5 held valid", 32'(evt_valid), 1);
    chk("R5 held level", 32'(evt_level), 9);

    lvl_en = 9'h1FB;                  // disable level 9
    @(negedge clk);
    chk("R4 disabled", 32'(evt_valid), 0);
    lvl_en = 9'h1FF;
    @(negedge clk);
    chk("R4 re-enabled", 32'(evt_level), 9);

    ack_at(32'h1000);
    chk("R6 active", 32'(active_lvls), 32'h0200);
    chk("R6 ret", ret_addr, 32'h1000);
    chk("R6 pending cleared", 32'(evt_valid), 0);

    pulse_req(8'h14);                 // levels 9 and 11
    chk("R7 same/lower wait", 32'(evt_valid), 0);
    pulse_req(8'h02);                 // level 8
    chk("R7 preempt valid", 32'(evt_valid), 1);
    chk("R7 preempt level", 32'(evt_level), 8);
    ack_at(32'h2000);
    chk("R7 nested active", 32'(active_lvls), 32'h0300);
    chk("R7 nested ret", ret_addr, 32'h2000);

    ack_at(32'h3000);
    chk("R9 ack idle active", 32'(active_lvls), 32'h0300);
    chk("R9 ack idle ret", ret_addr, 32'h2000);

    rti_once();
    chk("R8 first rti active", 32'(active_lvls), 32'h0200);
    chk("R8 first rti ret", ret_addr, 32'h1000);
    chk("R8 still blocked", 32'(evt_valid), 0);
    rti_once();
    chk("R8 second rti active", 32'(active_lvls), 0);
    chk("R8 second rti ret", ret_addr, 0);
    chk("R8 release level", 32'(evt_level), 9);

    rti_once();
    chk("R9 rti idle active", 32'(active_lvls), 0);
    chk("R9 rti idle valid", 32'(evt_valid), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule